// File: doc/BRIEF.md
# Paged Memory Mapper with Port Registers

This block places a 16 KB overlay over the bottom of a Z80 address space and splits it into four 4 KB slots. The first and last slots are pinned to page 0 of the flash (chip 0) and page 0 of the static RAM (chip 3). The two middle slots, area A and area B, each show any page of any chip. A page register and a two-bit chip field belong to each area, and both chip fields share one chip-select register.

Software programs the three registers with Z80 `OUT` writes to three fully decoded I/O ports. The registers cannot be read back. On every memory access inside the overlay, the block asserts exactly one active-low chip enable and builds a 20-bit chip-local address from an 8-bit page and a 12-bit offset. The `map_en` input stands in for the logic that decides when the overlay is switched in.

Top module: `mmap_pager`

## Requirements
- R1: A synchronous active-low reset clears page register A, page register B and the chip-select register to zero, so both middle areas then map to page 0 of chip 0.
- R2: An enabled access to 0x0000–0x0FFF always selects chip 0 (`ce_n` = 4'b1110) with `chip_addr` = {8'h00, addr[11:0]}, whatever the registers hold.
- R3: An enabled access to 0x3000–0x3FFF always selects chip 3 (`ce_n` = 4'b0111) with `chip_addr` = {8'h00, addr[11:0]}, whatever the registers hold.
- R4: An enabled access to 0x1000–0x1FFF selects the chip named by chip-select bits [1:0], and `chip_addr` = {page A, addr[11:0]}.
- R5: An enabled access to 0x2000–0x2FFF selects the chip named by chip-select bits [3:2], and `chip_addr` = {page B, addr[11:0]}.
- R6: On a clock edge where `iorq_n`=0, `wr_n`=0 and `rd_n`=1, the registers load as follows: port 0xE9 loads page A from the data bus, port 0xEB loads page B, and port 0xED loads the chip-select register from data[3:0] while data[7:4] are dropped. The port is `cpu_addr[7:0]`.
- R7: An I/O write whose low address byte is anything other than 0xE9, 0xEB or 0xED leaves all three registers unchanged.
- R8: An I/O read of the paging ports and a memory write to the same low addresses leave all three registers unchanged. The registers have no read path.
- R9: Chip 2 is not fitted. When an area selects chip index 2, no chip enable is asserted (`ce_n` = 4'b1111).
- R10: All chip enables stay high unless three conditions hold together: `mreq_n`=0, `map_en`=1 and addr[15:14]=2'b00.
- R11: At most one chip enable is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | Z80 address bus |
| cpu_data | input | 8 | Z80 data bus, sampled on I/O writes |
| iorq_n | input | 1 | I/O request, active low |
| mreq_n | input | 1 | Memory request, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| map_en | input | 1 | Overlay enable from the paging control logic |
| ce_n | output | 4 | Chip enables, one per chip, active low |
| chip_addr | output | 20 | Chip-local address: {page, offset} |

## Verification
The tests first give area A and area B different pages and different chips. This shows that each area reads its own page register and its own chip-select field, and not the other area's. The fixed slots are probed while the registers hold non-zero values, which separates pinned mapping from mapping that only looks pinned because the registers are at their reset value of zero. The tests also write to neighbouring port numbers, issue I/O reads and memory writes to the port addresses, and select chip 2, so that a decoder that is too loose or an enable that is not gated shows up as a changed page or a stray enable. A sweep over all sixteen chip-select values and all four slots checks that at most one enable is low.

// File: rtl/mmap_pkg.sv
// Package: shared widths and the mapping target type for the paged mapper.
// Assumes 4 KB pages, 8-bit page numbers and at most four chips.
package mmap_pkg;
    localparam int PAGE_W     = 8;
    localparam int OFS_W      = 12;
    localparam int NUM_CHIPS  = 4;
    localparam int CHIP_IDX_W = $clog2(NUM_CHIPS);
    localparam int CADDR_W    = PAGE_W + OFS_W;
    localparam int WIN_W      = OFS_W + 2;     // 16 KB window offset
    localparam int CSEL_W     = 2 * CHIP_IDX_W;

    typedef struct packed {
        logic [CHIP_IDX_W-1:0] chip;
        logic [PAGE_W-1:0]     page;
    } map_target_t;
endpackage

// File: rtl/mmap_port_regs.sv
// Port register file: decodes Z80 I/O writes on the full low address byte
// and loads page A, page B and the packed chip-select register.
// Assumes the write strobes are stable at the sampling clock edge; a write
// held over several edges simply reloads the same value.
module mmap_port_regs
    import mmap_pkg::*;
#(
    parameter logic [7:0] PORT_PAGE_A = 8'hE9,
    parameter logic [7:0] PORT_PAGE_B = 8'hEB,
    parameter logic [7:0] PORT_CSEL   = 8'hED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        io_port,
    input  logic [7:0]        wdata,
    input  logic              iorq_n,
    input  logic              wr_n,
    input  logic              rd_n,
    output logic [PAGE_W-1:0] page_a,
    output logic [PAGE_W-1:0] page_b,
    output logic [CSEL_W-1:0] chip_sel
);
    logic io_wr;

    // Qualify an I/O write cycle: request, write strobe, no read strobe.
    always_comb io_wr = !iorq_n && !wr_n && rd_n;

    // Load the addressed register; other ports leave everything alone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_a   <= '0;
            page_b   <= '0;
            chip_sel <= '0;
        end else if (io_wr) begin
            case (io_port)
                PORT_PAGE_A: page_a   <= wdata[PAGE_W-1:0];
                PORT_PAGE_B: page_b   <= wdata[PAGE_W-1:0];
                PORT_CSEL:   chip_sel <= wdata[CSEL_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mmap_window_decode.sv
// Window decoder: picks the slot from the window offset bits and forms the
// target chip index and the chip-local address.
// Assumes slot 0 and slot 3 are pinned to page 0 of FIXED_LO / FIXED_HI.
module mmap_window_decode
    import mmap_pkg::*;
#(
    parameter int FIXED_LO = 0,
    parameter int FIXED_HI = 3
) (
    input  logic [WIN_W-1:0]   win_addr,
    input  logic [PAGE_W-1:0]  page_a,
    input  logic [PAGE_W-1:0]  page_b,
    input  logic [CSEL_W-1:0]  chip_sel,
    output map_target_t        target,
    output logic [CADDR_W-1:0] chip_addr
);
    localparam logic [CHIP_IDX_W-1:0] LO_CHIP = CHIP_IDX_W'(FIXED_LO);
    localparam logic [CHIP_IDX_W-1:0] HI_CHIP = CHIP_IDX_W'(FIXED_HI);

    logic [1:0] slot;

    // Choose the chip and page for the slot the offset falls into.
    always_comb begin
        slot = win_addr[WIN_W-1:OFS_W];
        unique case (slot)
            2'd0: target = '{chip: LO_CHIP, page: '0};
            2'd1: target = '{chip: chip_sel[CHIP_IDX_W-1:0], page: page_a};
            2'd2: target = '{chip: chip_sel[CSEL_W-1:CHIP_IDX_W], page: page_b};
            default: target = '{chip: HI_CHIP, page: '0};
        endcase
    end

    // Chip-local address: selected page above the in-page offset.
    always_comb chip_addr = {target.page, win_addr[OFS_W-1:0]};
endmodule

// File: rtl/mmap_ce_gen.sv
// Chip-enable generator: one active-low enable per chip slot, asserted for
// the selected index while the access is qualified. Slots whose bit in
// CHIP_FITTED is clear never assert.
module mmap_ce_gen
    import mmap_pkg::*;
#(
    parameter logic [NUM_CHIPS-1:0] CHIP_FITTED = 4'b1011
) (
    input  logic                  active,
    input  logic [CHIP_IDX_W-1:0] chip,
    output logic [NUM_CHIPS-1:0]  ce_n
);
    for (genvar i = 0; i < NUM_CHIPS; i++) begin : g_ce
        if (CHIP_FITTED[i]) begin : g_fitted
            // Enable this chip when the access targets its index.
            always_comb ce_n[i] = !(active && (chip == CHIP_IDX_W'(i)));
        end else begin : g_absent
            // Absent chip: enable held inactive.
            always_comb ce_n[i] = 1'b1;
        end
    end
endmodule

// File: rtl/mmap_pager.sv
// Top: paged memory mapper for the bottom 16 KB of a Z80 address space.
// I/O writes program the paging registers; memory accesses inside the
// window with map_en high drive one chip enable and a 20-bit chip address.
// Assumes the synchronous reset is held for at least one clock edge.
module mmap_pager
    import mmap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          cpu_addr,
    input  logic [7:0]           cpu_data,
    input  logic                 iorq_n,
    input  logic                 mreq_n,
    input  logic                 wr_n,
    input  logic                 rd_n,
    input  logic                 map_en,
    output logic [NUM_CHIPS-1:0] ce_n,
    output logic [CADDR_W-1:0]   chip_addr
);
    logic [PAGE_W-1:0] page_a;
    logic [PAGE_W-1:0] page_b;
    logic [CSEL_W-1:0] chip_sel;
    map_target_t       target;
    logic              active;

    mmap_port_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_port  (cpu_addr[7:0]),
        .wdata    (cpu_data),
        .iorq_n   (iorq_n),
        .wr_n     (wr_n),
        .rd_n     (rd_n),
        .page_a   (page_a),
        .page_b   (page_b),
        .chip_sel (chip_sel)
    );

    mmap_window_decode u_dec (
        .win_addr  (cpu_addr[WIN_W-1:0]),
        .page_a    (page_a),
        .page_b    (page_b),
        .chip_sel  (chip_sel),
        .target    (target),
        .chip_addr (chip_addr)
    );

    // Access qualifier: memory cycle, overlay on, inside the bottom 16 KB.
    always_comb active = !mreq_n && map_en && (cpu_addr[15:WIN_W] == '0);

    mmap_ce_gen u_ce (
        .active (active),
        .chip   (target.chip),
        .ce_n   (ce_n)
    );
endmodule

// File: rtl/mmap_pager_chk.sv
// Checker: temporal properties of the mapper, bound into every instance of
// the top module. It watches the ports and the register outputs.
module mmap_pager_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic        iorq_n,
    input logic        mreq_n,
    input logic        wr_n,
    input logic        rd_n,
    input logic        map_en,
    input logic [3:0]  ce_n,
    input logic [19:0] chip_addr,
    input logic [7:0]  page_a,
    input logic [7:0]  page_b,
    input logic [3:0]  chip_sel
);
    logic io_wr_c;
    logic port_hit_c;
    logic qual_c;

    // Reference decodes written independently of the design.
    always_comb begin
        io_wr_c    = (iorq_n == 1'b0) && (wr_n == 1'b0) && (rd_n == 1'b1);
        port_hit_c = (cpu_addr[7:0] == 8'hE9) || (cpu_addr[7:0] == 8'hEB) ||
                     (cpu_addr[7:0] == 8'hED);
        qual_c     = (mreq_n == 1'b0) && map_en && (cpu_addr[15:14] == 2'b00);
    end

    p_at_most_one_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~ce_n) <= 1);

    p_gated_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !qual_c |-> (ce_n == 4'hF));

    p_fixed_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_c && cpu_addr[13:12] == 2'd0) |-> (ce_n == 4'b1110 && chip_addr[19:12] == 8'h00));

    p_fixed_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (qual_c && cpu_addr[13:12] == 2'd3) |-> (ce_n == 4'b0111 && chip_addr[19:12] == 8'h00));

    p_load_page_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_c && cpu_addr[7:0] == 8'hE9) |=> (page_a == $past(cpu_data)));

    p_load_csel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_c && cpu_addr[7:0] == 8'hED) |=> (chip_sel == $past(cpu_data[3:0])));

    p_other_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr_c && !port_hit_c) |=> ($stable(page_a) && $stable(page_b) && $stable(chip_sel)));

    p_no_io_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !io_wr_c |=> ($stable(page_a) && $stable(page_b) && $stable(chip_sel)));
endmodule

bind mmap_pager mmap_pager_chk u_chk (.*);

// File: tb/mmap_pager_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module mmap_pager_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_data;
    logic        iorq_n, mreq_n, wr_n, rd_n, map_en;
    logic [3:0]  ce_n;
    logic [19:0] chip_addr;

    int checks = 0;
    int errors = 0;

    mmap_pager u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .iorq_n(iorq_n), .mreq_n(mreq_n), .wr_n(wr_n), .rd_n(rd_n),
        .map_en(map_en), .ce_n(ce_n), .chip_addr(chip_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic idle();
        iorq_n = 1'b1; mreq_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    endtask

    // I/O cycle across one rising edge; is_write selects WR or RD strobe.
    task automatic io_cycle(input logic [7:0] port, input logic [7:0] d, input bit is_write);
        @(negedge clk);
        cpu_addr = {8'h00, port}; cpu_data = d; iorq_n = 1'b0;
        wr_n = !is_write; rd_n = is_write;
        @(negedge clk);
        idle();
    endtask

    // Memory write cycle across one rising edge with map_en low.
    task automatic mem_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        map_en = 1'b0; cpu_addr = a; cpu_data = d; mreq_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        idle(); map_en = 1'b1;
    endtask

    // Memory read probe sampled mid-cycle; chip_addr compared when chk_a.
    task automatic probe(input string req, input logic [15:0] a, input logic mq_n,
                         input logic en, input logic [3:0] exp_ce,
                         input logic [19:0] exp_a, input bit chk_a);
        @(negedge clk);
        cpu_addr = a; mreq_n = mq_n; rd_n = 1'b0; map_en = en;
        #1;
        checks++;
        if (ce_n !== exp_ce || (chk_a && chip_addr !== exp_a)) begin
            errors++;
            $display("FAIL %s: addr=%h ce_n=%b chip_addr=%h expected ce_n=%b chip_addr=%h",
                     req, a, ce_n, chip_addr, exp_ce, exp_a);
        end
        idle(); map_en = 1'b1;
    endtask

    task automatic t_reset();
        probe("R1", 16'h1234, 1'b0, 1'b1, 4'b1110, 20'h00234, 1'b1);
        probe("R1", 16'h2ABC, 1'b0, 1'b1, 4'b1110, 20'h00ABC, 1'b1);
    endtask

    task automatic t_fixed();
        io_cycle(8'hE9, 8'h55, 1'b1);
        io_cycle(8'hEB, 8'hAA, 1'b1);
        io_cycle(8'hED, 8'h0F, 1'b1);
        probe("R2", 16'h0123, 1'b0, 1'b1, 4'b1110, 20'h00123, 1'b1);
        probe("R2", 16'h0FFF, 1'b0, 1'b1, 4'b1110, 20'h00FFF, 1'b1);
        probe("R3", 16'h3FFF, 1'b0, 1'b1, 4'b0111, 20'h00FFF, 1'b1);
        probe("R3", 16'h3000, 1'b0, 1'b1, 4'b0111, 20'h00000, 1'b1);
    endtask

    task automatic t_areas();
        io_cycle(8'hE9, 8'h12, 1'b1);
        io_cycle(8'hEB, 8'h9C, 1'b1);
        io_cycle(8'hED, 8'h07, 1'b1);   // A -> chip 3, B -> chip 1
        probe("R4", 16'h1456, 1'b0, 1'b1, 4'b0111, 20'h12456, 1'b1);
        probe("R5", 16'h2789, 1'b0, 1'b1, 4'b1101, 20'h9C789, 1'b1);
        io_cycle(8'hED, 8'h0C, 1'b1);   // A -> chip 0, B -> chip 3
        probe("R4", 16'h1000, 1'b0, 1'b1, 4'b1110, 20'h12000, 1'b1);
        probe("R5", 16'h2FFF, 1'b0, 1'b1, 4'b0111, 20'h9CFFF, 1'b1);
        io_cycle(8'hED, 8'hF1, 1'b1);   // upper nibble dropped: A chip 1, B chip 0
        probe("R6", 16'h1ABC, 1'b0, 1'b1, 4'b1101, 20'h12ABC, 1'b1);
        probe("R6", 16'h2ABC, 1'b0, 1'b1, 4'b1110, 20'h9CABC, 1'b1);
    endtask

    task automatic t_chip2();
        io_cycle(8'hED, 8'h0A, 1'b1);   // both areas -> chip 2
        probe("R9", 16'h1000, 1'b0, 1'b1, 4'b1111, 20'h12000, 1'b1);
        probe("R9", 16'h2000, 1'b0, 1'b1, 4'b1111, 20'h9C000, 1'b1);
    endtask

    task automatic t_decode();
        io_cycle(8'hE9, 8'h21, 1'b1);
        io_cycle(8'hEB, 8'h43, 1'b1);
        io_cycle(8'hED, 8'h06, 1'b1);   // A -> chip 2, B -> chip 1
        io_cycle(8'hED, 8'h0D, 1'b1);   // A -> chip 1, B -> chip 3
        foreach (stray_ports[i]) io_cycle(stray_ports[i], 8'h77, 1'b1);
        probe("R7", 16'h1010, 1'b0, 1'b1, 4'b1101, 20'h21010, 1'b1);
        probe("R7", 16'h2020, 1'b0, 1'b1, 4'b0111, 20'h43020, 1'b1);
    endtask

    logic [7:0] stray_ports [6] = '{8'hE8, 8'hEA, 8'hEC, 8'hEE, 8'h69, 8'hE1};

    task automatic t_no_write();
        io_cycle(8'hE9, 8'h44, 1'b0);
        io_cycle(8'hEB, 8'h44, 1'b0);
        io_cycle(8'hED, 8'h00, 1'b0);
        mem_write(16'h00E9, 8'h44);
        mem_write(16'h00ED, 8'h00);
        probe("R8", 16'h1010, 1'b0, 1'b1, 4'b1101, 20'h21010, 1'b1);
        probe("R8", 16'h2020, 1'b0, 1'b1, 4'b0111, 20'h43020, 1'b1);
    endtask

    task automatic t_gate();
        probe("R10", 16'h1000, 1'b1, 1'b1, 4'b1111, 20'h0, 1'b0);
        probe("R10", 16'h0000, 1'b0, 1'b0, 4'b1111, 20'h0, 1'b0);
        probe("R10", 16'h4000, 1'b0, 1'b1, 4'b1111, 20'h0, 1'b0);
        probe("R10", 16'hF000, 1'b0, 1'b1, 4'b1111, 20'h0, 1'b0);
    endtask

    task automatic t_onehot();
        for (int cs = 0; cs < 16; cs++) begin
            io_cycle(8'hED, 8'(cs), 1'b1);
            for (int s = 0; s < 4; s++) begin
                @(negedge clk);
                cpu_addr = 16'(s << 12); mreq_n = 1'b0; rd_n = 1'b0;
                #1;
                checks++;
                if ($countones(~ce_n) > 1) begin
                    errors++;
                    $display("FAIL R11: cs=%0d slot=%0d ce_n=%b expected at most one low",
                             cs, s, ce_n);
                end
                idle();
            end
        end
    endtask

    initial begin
        idle(); map_en = 1'b1; cpu_addr = '0; cpu_data = '0; rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_fixed();
        t_areas();
        t_chip2();
        t_decode();
        t_no_write();
        t_gate();
        t_onehot();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule